// File: doc/BRIEF.md
# Streaming Vector Reduction Unit with Pivot Search

This block takes a vector of signed integers that arrives one element per clock cycle and reduces it to a single scalar. Four operations are available: largest value, smallest value, wrapping sum, and pivot search. Pivot search reports the position of the element with the greatest magnitude, which is the step that picks a pivot row in elimination-style linear solvers. Each element comes with a valid flag and a last flag. The operation code is taken from the first element of each vector. There is no fixed length, so successive vectors may be shorter or longer than the one before. A common case is a length that drops by one on every pass.

The result is registered. It appears together with a one-cycle done pulse in the cycle after the element marked last, and it holds until the next done pulse. A new vector may start in the very cycle that the previous result is presented. No idle cycle between vectors is needed.

Top module: `vred_unit`

## Requirements
- R1: The operation code `in_op` is captured with the first element of a vector and applies to the whole vector; `in_op` on any later element of the same vector has no effect. Encoding: 0 = MAX, 1 = MIN, 2 = SUM, 3 = PIVOT.
- R2: MAX returns the largest element as a signed value in `out_value`, and its zero-based position in `out_index`; when several elements equal the maximum, the lowest position is reported.
- R3: MIN returns the smallest element as a signed value and its zero-based position; when there are ties, the lowest position is reported.
- R4: SUM returns the two's-complement sum of all elements modulo 2^W, with `out_index` equal to 0.
- R5: `out_ovf` is 1 after a SUM vector in which at least one partial addition had a signed overflow, even if later additions bring the value back into range; it is 0 after every other operation.
- R6: PIVOT returns in `out_index` the position of the element with the greatest absolute value, and in `out_value` that element's signed value; ties go to the lowest position, and the most negative code counts as the largest magnitude.
- R7: `out_done` is high for exactly one cycle, in the cycle after a valid element flagged last; at all other times it is low, and the three result outputs keep their values between done pulses.
- R8: Any length from 1 to MAX_LEN is accepted per vector, and positions count from 0 at each vector's first element; a one-element vector yields index 0 and that element's value.
- R9: The first element of a new vector may arrive in the same cycle as the previous vector's done pulse; cycles with `in_valid` low inside or between vectors have no effect, whatever `in_last`, `in_data` and `in_op` hold.
- R10: After synchronous reset, `out_done`, `out_value`, `out_index` and `out_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element present this cycle |
| in_last | input | 1 | Element is the final one of its vector |
| in_op | input | 2 | Operation code, sampled with the first element |
| in_data | input | W | Signed element value |
| out_done | output | 1 | One-cycle pulse marking a new result |
| out_value | output | W | Reduced value, or the pivot element's value |
| out_index | output | $clog2(MAX_LEN) | Position of the selected element |
| out_ovf | output | 1 | Signed overflow seen during a SUM |

## Verification
Two things can happen in the same cycle here: the done pulse for one vector, and the acceptance of the first element of the next vector. During that cycle the element counter is being reset while the previous result is being presented. The bench provokes this by streaming vectors back to back with no gap, often with lengths that shrink by one each time and with the operation changing from vector to vector. It judges the outcome by matching every done pulse, in order, against a queue of results computed by a software model. A corrupted index, or an operation carried over from the previous vector, then shows up as a mismatch.

// File: rtl/vred_pkg.sv
package vred_pkg;

    typedef enum logic [1:0] {
        OP_MAX   = 2'd0,
        OP_MIN   = 2'd1,
        OP_SUM   = 2'd2,
        OP_PIVOT = 2'd3
    } vred_op_e;

    function automatic logic op_is_sum(vred_op_e op);
        return op == OP_SUM;
    endfunction

    function automatic vred_op_e op_decode(logic [1:0] code);
        return vred_op_e'(code);
    endfunction

endpackage

// File: rtl/vred_index_ctr.sv
module vred_index_ctr #(
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          last,
    output logic          first,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic          busy;
    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (step) begin
            if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                busy <= 1'b1;
                cnt  <= idx + ONE;
            end
        end
    end

    assign first = ~busy;
    assign idx   = busy ? cnt : '0;
endmodule

// File: rtl/vred_select.sv
module vred_select
    import vred_pkg::*;
#(
    parameter int W = 16
) (
    input  vred_op_e      op,
    input  logic [W-1:0]  cand,
    input  logic [W-1:0]  best,
    output logic          take
);
    logic [W:0] cand_ext, best_ext, cand_mag, best_mag;

    always_comb begin
        cand_ext = {cand[W-1], cand};
        best_ext = {best[W-1], best};
        cand_mag = cand_ext[W] ? (~cand_ext + 1'b1) : cand_ext;
        best_mag = best_ext[W] ? (~best_ext + 1'b1) : best_ext;
        unique case (op)
            OP_MAX:   take = $signed(cand) > $signed(best);
            OP_MIN:   take = $signed(cand) < $signed(best);
            OP_PIVOT: take = cand_mag > best_mag;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/vred_adder.sv
module vred_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         ovf
);
    always_comb begin
        s   = a + b;
        ovf = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    end
endmodule

// File: rtl/vred_unit.sv
module vred_unit
    import vred_pkg::*;
#(
    parameter int W       = 16,
    parameter int MAX_LEN = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_last,
    input  logic [1:0]                 in_op,
    input  logic [W-1:0]               in_data,
    output logic                       out_done,
    output logic [W-1:0]               out_value,
    output logic [$clog2(MAX_LEN)-1:0] out_index,
    output logic                       out_ovf
);
    localparam int IDX_W = $clog2(MAX_LEN);

    typedef struct packed {
        logic [W-1:0]     val;
        logic [IDX_W-1:0] idx;
        logic             ovf;
    } acc_t;

    acc_t             acc_q, acc_d, res_q;
    vred_op_e         op_q, op_eff;
    logic             first;
    logic [IDX_W-1:0] cur_idx;
    logic             take;
    logic [W-1:0]     sum;
    logic             sum_ovf;
    logic             done_q;

    vred_index_ctr #(.IW(IDX_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .step  (in_valid),
        .last  (in_last),
        .first (first),
        .idx   (cur_idx)
    );

    assign op_eff = first ? op_decode(in_op) : op_q;

    vred_select #(.W(W)) u_sel (
        .op   (op_eff),
        .cand (in_data),
        .best (acc_q.val),
        .take (take)
    );

    vred_adder #(.W(W)) u_add (
        .a   (acc_q.val),
        .b   (in_data),
        .s   (sum),
        .ovf (sum_ovf)
    );

    always_comb begin
        acc_d = acc_q;
        if (first) begin
            acc_d.val = in_data;
            acc_d.idx = '0;
            acc_d.ovf = 1'b0;
        end else if (op_is_sum(op_eff)) begin
            acc_d.val = sum;
            acc_d.idx = '0;
            acc_d.ovf = acc_q.ovf | sum_ovf;
        end else if (take) begin
            acc_d.val = in_data;
            acc_d.idx = cur_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            res_q  <= '0;
            op_q   <= OP_MAX;
            done_q <= 1'b0;
        end else begin
            done_q <= in_valid && in_last;
            if (in_valid) begin
                acc_q <= acc_d;
                if (first) op_q <= op_decode(in_op);
                if (in_last) res_q <= acc_d;
            end
        end
    end

    assign out_done  = done_q;
    assign out_value = res_q.val;
    assign out_index = res_q.idx;
    assign out_ovf   = res_q.ovf;
endmodule

// File: rtl/vred_checker.sv
module vred_checker
    import vred_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_last,
    input logic [1:0]    in_op,
    input logic [W-1:0]  in_data,
    input logic          out_done,
    input logic [W-1:0]  out_value,
    input logic [IW-1:0] out_index,
    input logic          out_ovf
);
    logic        mid;
    logic [IW:0] cnt, len_q;
    logic [1:0]  op_run, op_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid     <= 1'b0;
            cnt     <= '0;
            len_q   <= '0;
            op_run  <= 2'd0;
            op_done <= 2'd0;
        end else if (in_valid) begin
            if (in_last) begin
                mid     <= 1'b0;
                cnt     <= '0;
                len_q   <= (mid ? cnt : '0) + 1'b1;
                op_done <= mid ? op_run : in_op;
            end else begin
                mid <= 1'b1;
                cnt <= (mid ? cnt : '0) + 1'b1;
                if (!mid) op_run <= in_op;
            end
        end
    end

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> out_done);

    p_done_only_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> !out_done);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_value) && $stable(out_index) && $stable(out_ovf)));

    p_index_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        out_done |-> ({1'b0, out_index} < len_q));

    p_single_element_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && !mid) |=> (out_index == '0 && out_value == $past(in_data)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (out_done && op_done != 2'd2) |-> !out_ovf);

    p_sum_index_r4: assert property (@(posedge clk) disable iff (rst)
        (out_done && op_done == 2'd2) |-> (out_index == '0));
endmodule

bind vred_unit vred_checker #(.W(W), .IW(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_op     (in_op),
    .in_data   (in_data),
    .out_done  (out_done),
    .out_value (out_value),
    .out_index (out_index),
    .out_ovf   (out_ovf)
);

// File: tb/sim_vred_unit.sv
module sim_vred_unit;
    localparam int W       = 16;
    localparam int MAX_LEN = 64;
    localparam int IW      = $clog2(MAX_LEN);
    localparam int HI      = (1 << (W - 1)) - 1;
    localparam int LO      = -(1 << (W - 1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [1:0]    in_op = 2'd0;
    logic [W-1:0]  in_data = '0;
    logic          out_done;
    logic [W-1:0]  out_value;
    logic [IW-1:0] out_index;
    logic          out_ovf;

    always #10 clk = ~clk;

    vred_unit #(.W(W), .MAX_LEN(MAX_LEN)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_op(in_op), .in_data(in_data), .out_done(out_done),
        .out_value(out_value), .out_index(out_index), .out_ovf(out_ovf)
    );

    typedef struct {
        int    val;
        int    idx;
        int    ovf;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    vq[$];
    int    checks = 0;
    int    failures = 0;
    bit    mon_on = 1'b0;
    int    held_val = 0, held_idx = 0, held_ovf = 0;
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int x);
        logic [W-1:0] t;
        t = x[W-1:0];
        return $signed(t);
    endfunction

    function automatic int absv(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic exp_t model(input int op, input string tag);
        exp_t e;
        int acc, best, bi, ov, full;
        e.tag = tag;
        best = sx(vq[0]); bi = 0; acc = sx(vq[0]); ov = 0;
        for (int i = 1; i < vq.size(); i++) begin
            int x;
            x = sx(vq[i]);
            case (op)
                0: if (x > best) begin best = x; bi = i; end
                1: if (x < best) begin best = x; bi = i; end
                3: if (absv(x) > absv(best)) begin best = x; bi = i; end
                default: begin
                    full = acc + x;
                    if (full > HI || full < LO) ov = 1;
                    acc = sx(full);
                end
            endcase
        end
        if (op == 2) begin e.val = acc; e.idx = 0; e.ovf = ov; end
        else begin e.val = best; e.idx = bi; e.ovf = 0; end
        return e;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b0;
            in_last  = 1'b1;
            in_data  = W'(16'h5a5a);
            in_op    = 2'd3;
        end
    endtask

    // Drives vq as one vector; leaves in_valid high so a following call is back to back.
    task automatic send(input int op, input string tag, input bit gaps);
        sb.push_back(model(op, tag));
        for (int i = 0; i < vq.size(); i++) begin
            if (gaps && (i % 2 == 1)) idle(1);
            @(posedge clk); #2;
            in_valid = 1'b1;
            in_data  = vq[i][W-1:0];
            in_last  = (i == vq.size() - 1);
            in_op    = (i == 0) ? op[1:0] : ~op[1:0];
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (out_done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check($signed(out_value) == e.val, e.tag, "value", $signed(out_value), e.val);
                    check(int'(out_index) == e.idx, e.tag, "index", int'(out_index), e.idx);
                    check(int'(out_ovf) == e.ovf, e.tag, "ovf", int'(out_ovf), e.ovf);
                end
                held_val = $signed(out_value);
                held_idx = out_index;
                held_ovf = out_ovf;
            end else begin
                // R7: outputs hold between done pulses
                check($signed(out_value) == held_val && int'(out_index) == held_idx
                      && int'(out_ovf) == held_ovf, "R7", "hold", $signed(out_value), held_val);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(out_done == 1'b0, "R10", "done", out_done, 0);
        check(out_value == '0, "R10", "value", out_value, 0);
        check(out_index == '0, "R10", "index", out_index, 0);
        check(out_ovf == 1'b0, "R10", "ovf", out_ovf, 0);
        mon_on = 1'b1;

        // R2: max with duplicate maxima
        vq = '{3, -5, 7, 7, 2};            send(0, "R2", 1'b0); idle(2);
        // R3: min with duplicate minima
        vq = '{4, -9, 0, -9};              send(1, "R3", 1'b0); idle(2);
        // R4: small sum with negatives
        vq = '{10, -3, 25, -40};           send(2, "R4", 1'b0); idle(2);
        // R5: overflow sticks even after returning into range
        vq = '{HI, 1, -5};                 send(2, "R5", 1'b0); idle(2);
        vq = '{LO, -1, 2};                 send(2, "R5", 1'b0); idle(2);
        // R6: pivot, magnitude tie goes to lowest index
        vq = '{3, -8, 8, 5};               send(3, "R6", 1'b0); idle(2);
        vq = '{LO, HI, -HI};               send(3, "R6", 1'b0); idle(2);
        // R1: op on later elements (driven inverted) ignored; change per vector
        vq = '{1, 2, 3, 4};                send(1, "R1", 1'b0);
        vq = '{1, 2, 3, 4};                send(0, "R1", 1'b0); idle(2);
        // R8: length-one vectors for each op
        for (int op = 0; op < 4; op++) begin
            vq = '{-77 + op};              send(op, "R8", 1'b0);
        end
        idle(2);
        // R9: gaps inside vectors with garbage on idle cycles
        vq = '{6, -20, 11, 19, -2};        send(3, "R9", 1'b1);
        vq = '{6, -20, 11, 19, -2};        send(2, "R9", 1'b1); idle(2);
        // R8/R9: shrinking lengths, back to back, rotating ops
        for (int k = 0; k < 4; k++) begin
            for (int len = 12; len >= 1; len--) begin
                vq.delete();
                for (int i = 0; i < len; i++)
                    vq.push_back(((k * 37 + i * 53 + len * 11) % 201) - 100);
                send((len + k) % 4, "R9", 1'b0);
            end
        end
        idle(1);
        // R8: longest vector
        vq.delete();
        for (int i = 0; i < MAX_LEN; i++) vq.push_back((i * 97) % 301 - 150);
        send(3, "R8", 1'b0);
        vq.delete();
        for (int i = 0; i < MAX_LEN; i++) vq.push_back((i * 97) % 301 - 150);
        send(0, "R8", 1'b0);
        idle(4);

        check(sb.size() == 0, "R7", "pending results", sb.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule